// File: doc/BRIEF.md
# Alert Event Message Trigger

This block watches seven platform status lines and decides when a management alert message has to go out over the LAN path. Every line has its own edge rule. Some lines count only when they assert. Others count on both assertion and deassertion. A few are qualified by the power state or by a disable control. Each qualifying edge sets a sticky pending bit for its source. The pending bits are merged into one request that is offered to a downstream transmitter.

The request uses a valid/busy handshake. The block raises `msg_valid_o` only when something is pending and the transmitter is idle. With the request it presents a snapshot of the pending bits and a 4-bit sequence number, one higher than the previous message. The transmitter takes the message on the first cycle in which valid is high and busy is low. At that edge the snapshotted bits are cleared. An event that arrives after the snapshot stays pending and goes out in a follow-up message with the next sequence number.

The power state input is encoded as 0 = working, 1 = suspended with memory held, 2 = soft off and 3 = mechanical off. Core power counts as on only in state 0. All inputs are synchronous to `clk`.

Top module: `alert_event_trig`

## Requirements
- R1: After reset `msg_valid_o` is 0, `msg_events_o` is 0, `msg_seq_o` is 0 and nothing is pending. The first message after reset carries sequence 1.
- R2: A low-to-high change on `tamper_i` sets event bit 0. A high-to-low change on `tamper_i` produces no message.
- R3: Any change on `hot_i` sets event bit 1, but only while `pwr_state_i` is 0. Changes made in any other power state produce no message.
- R4: A rising edge on `wdt_expired_i` sets event bit 2 and a rising edge on `pwrfail_i` sets event bit 3. The falling edges of both produce no message.
- R5: A rising edge on `sendnow_i` sets event bit 4 only while `pwr_state_i` is 0. Its falling edge, and any edge in another power state, produce no message.
- R6: Any change on `smb_alert_i` sets event bit 5 while `smb_alert_dis_i` is 0. While `smb_alert_dis_i` is 1, changes produce no message.
- R7: Any change on `batt_low_i` sets event bit 6.
- R8: Pending bits are sticky. Events that become pending before a request is raised are merged into a single message. A bit clears only when a message carrying it is accepted.
- R9: `msg_valid_o` rises only if at least one bit is pending and `tx_busy_i` is 0. Once high it stays high, with `msg_events_o` and `msg_seq_o` unchanged, until a cycle with `tx_busy_i` at 0 accepts it. It then falls on the next cycle. A message never carries an empty event field.
- R10: Each new message carries the previous sequence number plus one, modulo 16 (15 is followed by 0).
- R11: An event that arrives while a message is held waiting is absent from that message. It is delivered in the next message, whose sequence number is one higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tamper_i | input | 1 | Chassis intrusion status |
| hot_i | input | 1 | Processor over-temperature status |
| wdt_expired_i | input | 1 | Watchdog expiry status |
| pwrfail_i | input | 1 | Processor power-failure status |
| sendnow_i | input | 1 | Software request to send a message |
| smb_alert_i | input | 1 | SMBus alert line |
| smb_alert_dis_i | input | 1 | 1 = ignore the SMBus alert line |
| batt_low_i | input | 1 | Low battery status |
| pwr_state_i | input | 2 | 0 working, 1 suspended, 2 soft off, 3 mechanical off |
| tx_busy_i | input | 1 | Transmitter busy; a message is accepted when valid and this is 0 |
| msg_valid_o | output | 1 | Message request |
| msg_events_o | output | 7 | Events carried by the offered message (bit order as in R2 to R7) |
| msg_seq_o | output | SEQ_W | Sequence number of the offered message |

## Verification
The assertions take for granted that every status input is already synchronous and changes at most once per clock. They also assume the transmitter follows the valid/busy rule: it never withdraws a message it has not taken, and it takes it only when busy is low. The stimulus changes inputs one clock phase away from the sampling edge. It keeps every status line low through reset, so no edge is seen at reset exit. It drives `tx_busy_i` only as a level that it sets and clears between edges. Power state and the disable control are changed only while the affected line is quiet. As a result every event follows a single, defined gating condition.

// File: rtl/alert_evt_pkg.sv
package alert_evt_pkg;

  localparam int SRC_N = 7;

  localparam int IDX_TAMPER = 0;
  localparam int IDX_HOT    = 1;
  localparam int IDX_WDT    = 2;
  localparam int IDX_PFAIL  = 3;
  localparam int IDX_SEND   = 4;
  localparam int IDX_SMB    = 5;
  localparam int IDX_BATT   = 6;

  // 1 = source reports both edges, 0 = rising edge only
  localparam logic [SRC_N-1:0] BOTH_EDGE_MASK = 7'b110_0010;

  typedef enum logic [1:0] {
    PWR_WORK  = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_SOFT  = 2'd2,
    PWR_MECH  = 2'd3
  } pwr_e;

endpackage

// File: rtl/alert_edge.sv
module alert_edge #(
  parameter bit BOTH = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic gate_i,
  output logic evt_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  generate
    if (BOTH) begin : g_both
      assign evt_o = gate_i & (sig_i ^ prev_q);
    end else begin : g_rise
      assign evt_o = gate_i & sig_i & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/alert_pend.sv
module alert_pend #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] keep;

  assign keep = pend_o & ~({N{clr_en_i}} & clr_mask_i);

  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= keep | evt_i;
  end

  // R8: bits survive unless a message carrying them is accepted
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & $past(keep)) == $past(keep)));

  // R8: only bits that are pending can be cleared
  a_r8_clear_pending: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |-> ((clr_mask_i & ~pend_o) == '0));

endmodule

// File: rtl/alert_msg_ctrl.sv
module alert_msg_ctrl #(
  parameter int N     = 7,
  parameter int SEQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend_i,
  input  logic             tx_busy_i,
  output logic             msg_valid_o,
  output logic [N-1:0]     msg_events_o,
  output logic [SEQ_W-1:0] msg_seq_o,
  output logic             clr_en_o,
  output logic [N-1:0]     clr_mask_o
);

  logic accept;
  logic launch;

  assign accept     = msg_valid_o & ~tx_busy_i;
  assign launch     = ~msg_valid_o & (|pend_i) & ~tx_busy_i;
  assign clr_en_o   = accept;
  assign clr_mask_o = msg_events_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid_o  <= 1'b0;
      msg_events_o <= '0;
      msg_seq_o    <= '0;
    end else if (accept) begin
      msg_valid_o  <= 1'b0;
    end else if (launch) begin
      msg_valid_o  <= 1'b1;
      msg_events_o <= pend_i;
      msg_seq_o    <= msg_seq_o + 1'b1;
    end
  end

  // R9: a held request keeps its content
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && tx_busy_i) |=>
      (msg_valid_o && $stable(msg_events_o) && $stable(msg_seq_o)));

  // R9: never an empty message
  a_r9_nonempty: assert property (@(posedge clk) disable iff (rst)
    msg_valid_o |-> (msg_events_o != '0));

  // R9: request raised only with pending work and idle transmitter
  a_r9_raise_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid_o) |-> $past(!tx_busy_i && (pend_i != '0)));

  // R9: accepted request drops
  a_r9_drop: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !tx_busy_i) |=> !msg_valid_o);

  // R10: sequence advances by one per message
  a_r10_seq_step: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid_o) |-> (msg_seq_o == SEQ_W'($past(msg_seq_o) + 1'b1)));

endmodule

// File: rtl/alert_event_trig.sv
module alert_event_trig
  import alert_evt_pkg::*;
#(
  parameter int SEQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tamper_i,
  input  logic             hot_i,
  input  logic             wdt_expired_i,
  input  logic             pwrfail_i,
  input  logic             sendnow_i,
  input  logic             smb_alert_i,
  input  logic             smb_alert_dis_i,
  input  logic             batt_low_i,
  input  logic [1:0]       pwr_state_i,
  input  logic             tx_busy_i,
  output logic             msg_valid_o,
  output logic [SRC_N-1:0] msg_events_o,
  output logic [SEQ_W-1:0] msg_seq_o
);

  logic [SRC_N-1:0] raw;
  logic [SRC_N-1:0] gate;
  logic [SRC_N-1:0] evt;
  logic [SRC_N-1:0] pend;
  logic [SRC_N-1:0] clr_mask;
  logic             clr_en;
  logic             core_on;

  assign core_on = (pwr_state_i == PWR_WORK);

  always_comb begin
    raw              = '0;
    raw[IDX_TAMPER]  = tamper_i;
    raw[IDX_HOT]     = hot_i;
    raw[IDX_WDT]     = wdt_expired_i;
    raw[IDX_PFAIL]   = pwrfail_i;
    raw[IDX_SEND]    = sendnow_i;
    raw[IDX_SMB]     = smb_alert_i;
    raw[IDX_BATT]    = batt_low_i;

    gate             = '1;
    gate[IDX_HOT]    = core_on;
    gate[IDX_SEND]   = core_on;
    gate[IDX_SMB]    = ~smb_alert_dis_i;
  end

  generate
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
      alert_edge #(.BOTH(BOTH_EDGE_MASK[g])) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (raw[g]),
        .gate_i (gate[g]),
        .evt_o  (evt[g])
      );
    end
  endgenerate

  alert_pend #(.N(SRC_N)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .clr_en_i   (clr_en),
    .clr_mask_i (clr_mask),
    .pend_o     (pend)
  );

  alert_msg_ctrl #(.N(SRC_N), .SEQ_W(SEQ_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .pend_i       (pend),
    .tx_busy_i    (tx_busy_i),
    .msg_valid_o  (msg_valid_o),
    .msg_events_o (msg_events_o),
    .msg_seq_o    (msg_seq_o),
    .clr_en_o     (clr_en),
    .clr_mask_o   (clr_mask)
  );

  // R2: intrusion bit only becomes pending after the line was high
  a_r2_tamper_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[IDX_TAMPER]) |-> $past(tamper_i));

  // R3: over-temperature events only with core power on
  a_r3_hot_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[IDX_HOT]) |-> $past(pwr_state_i == PWR_WORK));

  // R5: software request only honoured in the working state
  a_r5_send_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[IDX_SEND]) |-> $past((pwr_state_i == PWR_WORK) && sendnow_i));

  // R6: SMBus alert events only while not disabled
  a_r6_smb_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[IDX_SMB]) |-> $past(!smb_alert_dis_i));

endmodule

// File: tb/alert_event_trig_bench.sv
`timescale 1ns/100ps
module alert_event_trig_bench;
  import alert_evt_pkg::*;

  localparam int SEQ_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tamper = 0, hot = 0, wdt = 0, pfail = 0, sendnow = 0;
  logic smb = 0, smb_dis = 0, batt = 0, busy = 0;
  logic [1:0] pwr = 2'd0;
  logic msg_valid;
  logic [SRC_N-1:0] msg_events;
  logic [SEQ_W-1:0] msg_seq;

  always #2 clk = ~clk;

  alert_event_trig #(.SEQ_W(SEQ_W)) u_alert_event_trig (
    .clk(clk), .rst(rst), .tamper_i(tamper), .hot_i(hot),
    .wdt_expired_i(wdt), .pwrfail_i(pfail), .sendnow_i(sendnow),
    .smb_alert_i(smb), .smb_alert_dis_i(smb_dis), .batt_low_i(batt),
    .pwr_state_i(pwr), .tx_busy_i(busy), .msg_valid_o(msg_valid),
    .msg_events_o(msg_events), .msg_seq_o(msg_seq)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [SEQ_W-1:0] exp_seq = '0;
  logic [SRC_N+SEQ_W-1:0] exp_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_msg(logic [SRC_N-1:0] mask);
    exp_seq = exp_seq + 1'b1;
    exp_q.push_back({mask, exp_seq});
  endtask

  task automatic quiet(string req);
    cur_req = req;
    step(6);
    check(req, {31'd0, msg_valid}, 32'd0);
    check(req, exp_q.size(), 0);
  endtask

  task automatic drained(string req);
    cur_req = req;
    step(6);
    check(req, exp_q.size(), 0);
  endtask

  // monitor: sample half a nanosecond before each rising edge
  always begin
    @(negedge clk);
    #1.5;
    if (!rst && msg_valid && !busy) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s unexpected message actual=%0h/%0d expected=none",
                 cur_req, msg_events, msg_seq);
      end else begin
        logic [SRC_N+SEQ_W-1:0] e;
        e = exp_q.pop_front();
        if ({msg_events, msg_seq} !== e) begin
          bad++;
          $display("FAIL %s R10 message actual=%0h/%0d expected=%0h/%0d",
                   cur_req, msg_events, msg_seq,
                   e[SRC_N+SEQ_W-1:SEQ_W], e[SEQ_W-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1", {31'd0, msg_valid}, 32'd0);
    check("R1", {25'd0, msg_events}, 32'd0);
    check("R1", {28'd0, msg_seq}, 32'd0);
    quiet("R1");

    // R2 intrusion: rising only (first message checks seq 1 for R1)
    cur_req = "R2"; expect_msg(7'b000_0001); tamper = 1; drained("R2");
    tamper = 0; quiet("R2");

    // R3 over-temperature, both edges when powered
    cur_req = "R3"; expect_msg(7'b000_0010); hot = 1; drained("R3");
    expect_msg(7'b000_0010); hot = 0; drained("R3");
    pwr = 2'd1; step(1); hot = 1; quiet("R3"); hot = 0; quiet("R3");
    pwr = 2'd2; step(1); hot = 1; quiet("R3"); hot = 0; quiet("R3");
    pwr = 2'd0; step(1);

    // R4 watchdog and power failure, rising only
    cur_req = "R4"; expect_msg(7'b000_0100); wdt = 1; drained("R4");
    wdt = 0; quiet("R4");
    expect_msg(7'b000_1000); pfail = 1; drained("R4");
    pfail = 0; quiet("R4");

    // R5 software request
    cur_req = "R5"; expect_msg(7'b001_0000); sendnow = 1; drained("R5");
    sendnow = 0; quiet("R5");
    pwr = 2'd1; step(1); sendnow = 1; quiet("R5"); sendnow = 0; quiet("R5");
    pwr = 2'd0; step(1);

    // R6 SMBus alert
    cur_req = "R6"; expect_msg(7'b010_0000); smb = 1; drained("R6");
    expect_msg(7'b010_0000); smb = 0; drained("R6");
    smb_dis = 1; step(1); smb = 1; quiet("R6"); smb = 0; quiet("R6");
    smb_dis = 0; step(1);

    // R7 battery low
    cur_req = "R7"; expect_msg(7'b100_0000); batt = 1; drained("R7");
    expect_msg(7'b100_0000); batt = 0; drained("R7");

    // R8 merge of simultaneous events
    cur_req = "R8"; expect_msg(7'b100_0101);
    tamper = 1; wdt = 1; batt = 1; drained("R8");
    expect_msg(7'b100_0000);
    tamper = 0; wdt = 0; batt = 0; drained("R8");

    // R9 no request while busy
    cur_req = "R9"; busy = 1; hot = 1; step(4);
    check("R9", {31'd0, msg_valid}, 32'd0);
    expect_msg(7'b000_0010); busy = 0; drained("R9");

    // R11 rollover of an event arriving while held
    cur_req = "R11";
    expect_msg(7'b000_1000); expect_msg(7'b010_0000);
    pfail = 1; step(2);
    busy = 1; smb = 1; step(3);
    check("R9", {31'd0, msg_valid}, 32'd1);
    check("R11", {25'd0, msg_events}, 32'h08);
    busy = 0; step(8);
    check("R11", exp_q.size(), 0);

    // R10 wrap of the sequence number
    cur_req = "R10";
    for (int i = 0; i < 18; i++) begin
      expect_msg(7'b100_0000); batt = ~batt; step(5);
    end
    drained("R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule